// File: doc/BRIEF.md
# Legacy Interrupt Status and Mask Register

This block is one 32-bit control word of a host bridge. It collects four level-sensitive legacy interrupt lines (A to D) into sticky pending bits, and software acknowledges each pending bit by writing a one to it. The same word holds a per-line enable for each of the four lines, enables for eight error-event sources, seven bus-master priority flags and a four-bit target-ready wait count. The block drives one registered interrupt request toward a parent interrupt controller.

Software reaches the word through a plain write port with four byte enables and a read bus that always shows the current word. Error events come from outside the block as one-cycle strobes. Pending bits share a word with ordinary read/write fields. A read-modify-write must therefore write the pending bits back as zero, or it acknowledges lines that software has not yet serviced.

Top module: `intx_irq_reg`

## Requirements
- R1: After reset, `rdData` reads 0x00000000 and `irqOut` is 0, so every source starts disabled and nothing is pending.
- R2: When `intxIn[i]` is high at a clock edge, pending bit 28+i (line A at bit 28, line D at bit 31) reads 1 after that edge. The bit stays 1 after the input falls, until software acknowledges it.
- R3: A write with `wrBe[3]` set clears every pending bit whose `wrData` bit is 1. A pending bit written with 0 keeps its value. Without `wrBe[3]`, no pending bit changes.
- R4: If a line's input is still high on the edge where its pending bit is acknowledged, the bit reads 1 after that edge.
- R5: Bits 25..22 enable lines D..A (line A at bit 22, 1 enables the line). They can be read and written. `irqOut` is 1 one clock after a cycle in which any pending bit has its enable set.
- R6: `errEvt` bit k is gated by an enable bit, and 1 enables the source. The bit pairs are: k=0 with bit 16, k=1 with bit 17, k=2 with bit 18, k=3 with bit 19, k=4 with bit 20, k=5 with bit 21, k=6 with bit 26, k=7 with bit 27. A strobe on an enabled source makes `irqOut` 1 on the following cycle. A strobe on a disabled source leaves `irqOut` at 0.
- R7: Bits 14..8 (priority flags) and bits 3..0 (wait count) can be read and written. Bit 15 and bits 7..4 always read 0.
- R8: During a write, only the bytes whose `wrBe` bit is set change. Byte n covers bits 8n+7..8n.
- R9: A write with `wrBe`=4'b1100 and `wrData[31:16]`=0xF000 clears all pending bits and all line and error enables in one access. Two clocks after that write, `irqOut` is 0.
- R10: While `wrEn` is low, bits 27..0 keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the word |
| wrBe | input | 4 | Byte enables for the write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Current value of the word |
| intxIn | input | 4 | Legacy interrupt lines, bit 0 is line A |
| errEvt | input | 8 | One-cycle error event strobes |
| irqOut | output | 1 | Registered combined interrupt request |

## Verification
The read/write fields are driven through every single-byte-lane pattern and through a full-word write. This separates a lane-decode fault from a field-mask fault, and shows any reserved bit that leaks.

The pending logic is tried in three ways:
- a one-cycle pulse, which shows stickiness;
- an acknowledge written as zero against an acknowledge written as one;
- an acknowledge while the line is still high, which tells set priority apart from clear priority.

The interrupt request is checked with a line disabled and then enabled, with an error strobe on an enabled source and on a disabled one, and around the half-word write that clears everything. This separates masking faults from faults in the one-cycle latency.

// File: rtl/intx_irq_reg_pkg.sv
package intx_irq_reg_pkg;
  localparam int REG_W     = 32;
  localparam int NUM_LANES = REG_W / 8;
  localparam int NUM_LINES = 4;
  localparam int NUM_ERR   = 8;
  localparam int STAT_LSB  = 28;
  localparam int EN_LSB    = 22;
  localparam int ERRLO_LSB = 16;
  localparam int ERRLO_W   = 6;
  localparam int ERRHI_LSB = 26;
  localparam int ERRHI_W   = NUM_ERR - ERRLO_W;
  // bits kept by the control part: 27..16, 14..8, 3..0
  localparam logic [REG_W-1:0] RW_MASK = 32'h0FFF_7F0F;

  typedef struct packed {
    logic [NUM_LANES-1:0] laneWr;
    logic [NUM_LINES-1:0] ackLine;
  } regStrobe_t;
endpackage

// File: rtl/intx_irq_reg_ctrl.sv
module intx_irq_reg_ctrl
  import intx_irq_reg_pkg::*;
(
  input  logic                 wrEn,
  input  logic [NUM_LANES-1:0] wrBe,
  input  logic [REG_W-1:0]     wrData,
  output regStrobe_t           strb
);
  always_comb begin
    strb.laneWr  = wrEn ? wrBe : '0;
    strb.ackLine = (wrEn && wrBe[NUM_LANES-1]) ? wrData[STAT_LSB +: NUM_LINES] : '0;
  end
endmodule

// File: rtl/intx_irq_reg_datapath.sv
module intx_irq_reg_datapath
  import intx_irq_reg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strb,
  input  logic [REG_W-1:0]     wrData,
  input  logic [NUM_LINES-1:0] intxIn,
  input  logic [NUM_ERR-1:0]   errEvt,
  output logic [REG_W-1:0]     rdData,
  output logic                 irqOut
);
  logic [NUM_LINES-1:0] statQ;
  logic [REG_W-1:0]     cfgQ;
  logic [NUM_LINES-1:0] lineEn;
  logic [NUM_ERR-1:0]   errEn;
  logic                 irqNext;

  always_ff @(posedge clk) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~strb.ackLine) | intxIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else begin
      for (int b = 0; b < NUM_LANES; b++) begin
        if (strb.laneWr[b]) cfgQ[8*b +: 8] <= wrData[8*b +: 8] & RW_MASK[8*b +: 8];
      end
    end
  end

  always_comb begin
    lineEn  = cfgQ[EN_LSB +: NUM_LINES];
    errEn   = {cfgQ[ERRHI_LSB +: ERRHI_W], cfgQ[ERRLO_LSB +: ERRLO_W]};
    irqNext = (|(statQ & lineEn)) | (|(errEvt & errEn));
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= irqNext;
  end

  assign rdData = {statQ, cfgQ[STAT_LSB-1:0]};
endmodule

// File: rtl/intx_irq_reg.sv
module intx_irq_reg
  import intx_irq_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrBe,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic [3:0]  intxIn,
  input  logic [7:0]  errEvt,
  output logic        irqOut
);
  regStrobe_t strb;

  intx_irq_reg_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrBe   (wrBe),
    .wrData (wrData),
    .strb   (strb)
  );

  intx_irq_reg_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .intxIn (intxIn),
    .errEvt (errEvt),
    .rdData (rdData),
    .irqOut (irqOut)
  );
endmodule

// File: rtl/intx_irq_reg_checker.sv
module intx_irq_reg_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [3:0]  wrBe,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic [3:0]  intxIn,
  input logic [7:0]  errEvt,
  input logic        irqOut
);
  logic [3:0] ackSeen;
  logic       causeSeen;
  assign ackSeen   = (wrEn && wrBe[3]) ? wrData[31:28] : 4'b0;
  assign causeSeen = (|(rdData[31:28] & rdData[25:22])) |
                     (|(errEvt & {rdData[27:26], rdData[21:16]}));

  AST_PENDING_SETS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rdData[31:28] & $past(intxIn)) == $past(intxIn))); // R2

  AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(rdData[31:28] & ~ackSeen) & ~rdData[31:28]) == 4'b0)); // R3

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[15] == 1'b0) && (rdData[7:4] == 4'b0)); // R7

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(causeSeen))); // R5

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData[27:0])); // R10
endmodule

bind intx_irq_reg intx_irq_reg_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrBe   (wrBe),
  .wrData (wrData),
  .rdData (rdData),
  .intxIn (intxIn),
  .errEvt (errEvt),
  .irqOut (irqOut)
);

// File: tb/intx_irq_reg_test.sv
module intx_irq_reg_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NUM_VEC = 10;
  // {byte enables, write data, expected read}
  localparam logic [67:0] VECS [NUM_VEC] = '{
    {4'hF, 32'hFFFF_FFFF, 32'h0FFF_7F0F},
    {4'h1, 32'h0000_0000, 32'h0FFF_7F00},
    {4'h2, 32'h0000_0000, 32'h0FFF_0000},
    {4'h4, 32'h0000_0000, 32'h0F00_0000},
    {4'h8, 32'h0000_0000, 32'h0000_0000},
    {4'h4, 32'h00AA_0000, 32'h00AA_0000},
    {4'h2, 32'h0000_5500, 32'h00AA_5500},
    {4'h1, 32'h0000_00F5, 32'h00AA_5505},
    {4'h8, 32'h3C00_0000, 32'h0CAA_5505},
    {4'hF, 32'h0000_0000, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrBe = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  intxIn = '0;
  logic [7:0]  errEvt = '0;
  logic        irqOut;
  int checks = 0;
  int errors = 0;

  intx_irq_reg uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBe(wrBe), .wrData(wrData),
    .rdData(rdData), .intxIn(intxIn), .errEvt(errEvt), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrBe = be; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrBe = '0; wrData = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 read", rdData, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);

    // R7 R8 field and lane table
    for (int i = 0; i < NUM_VEC; i++) begin
      wr(VECS[i][67:64], VECS[i][63:32]);
      check("R8 R7 lane write", rdData, VECS[i][31:0]);
    end
    repeat (3) @(negedge clk);
    check("R10 hold", rdData, 32'h0);

    // R2 sticky pending, line disabled
    intxIn = 4'b0001;
    @(negedge clk);
    intxIn = 4'b0000;
    check("R2 set", {28'b0, rdData[31:28]}, 32'h1);
    repeat (3) @(negedge clk);
    check("R2 sticky", {28'b0, rdData[31:28]}, 32'h1);
    check("R5 masked irq", {31'b0, irqOut}, 32'h0);

    // R5 enable line A
    wr(4'h4, 32'h0040_0000);
    @(negedge clk);
    check("R5 enabled irq", {31'b0, irqOut}, 32'h1);

    // R3 write-one-to-clear
    wr(4'h8, 32'h0000_0000);
    check("R3 zero keeps", {28'b0, rdData[31:28]}, 32'h1);
    wr(4'h7, 32'hF000_0000);
    check("R3 no lane keeps", {28'b0, rdData[31:28]}, 32'h1);
    wr(4'h8, 32'h1000_0000);
    check("R3 one clears", {28'b0, rdData[31:28]}, 32'h0);
    @(negedge clk);
    check("R5 irq drops", {31'b0, irqOut}, 32'h0);

    // R4 ack while line high
    intxIn = 4'b0010;
    @(negedge clk);
    wr(4'h8, 32'h2000_0000);
    check("R4 resets", {28'b0, rdData[31:28]}, 32'h2);
    intxIn = 4'b0000;
    wr(4'h8, 32'h2000_0000);
    check("R4 clears", {28'b0, rdData[31:28]}, 32'h0);

    // R6 error enables
    wr(4'hF, 32'h0001_0000);
    @(negedge clk);
    errEvt = 8'h01;
    @(negedge clk);
    errEvt = 8'h00;
    check("R6 enabled strobe", {31'b0, irqOut}, 32'h1);
    @(negedge clk);
    check("R6 strobe over", {31'b0, irqOut}, 32'h0);
    errEvt = 8'h02;
    @(negedge clk);
    errEvt = 8'h00;
    check("R6 disabled strobe", {31'b0, irqOut}, 32'h0);
    wr(4'hF, 32'h0800_0000);
    errEvt = 8'h80;
    @(negedge clk);
    errEvt = 8'h00;
    check("R6 high source", {31'b0, irqOut}, 32'h1);

    // R9 half-word clear
    wr(4'hF, 32'h03C0_0000);
    intxIn = 4'b1111;
    @(negedge clk);
    intxIn = 4'b0000;
    @(negedge clk);
    check("R9 setup pending", rdData, 32'hF3C0_0000);
    check("R9 setup irq", {31'b0, irqOut}, 32'h1);
    wr(4'hC, 32'hF000_0000);
    check("R9 cleared", rdData, 32'h0);
    @(negedge clk);
    check("R9 irq low", {31'b0, irqOut}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule